// File: doc/BRIEF.md
# Flash bank and charge pump sleep sequencer

This block decides when a group of flash banks and the charge pump they share may go to sleep, and when they may come back. Each bank watches its own access strobe. Once its fall-back mode is set to sleep and it has been idle for a programmable number of cycles, it drops to sleep. The pump follows only after every bank is asleep. One cycle after the pump sleeps, the block tells the clock controller that the system bus clock may be stopped.

A wake request reverses the order. The pump comes back to active at once. A wake delay counter then runs at half the bus clock rate, and the sleeping banks stay in a waking state until it expires. Only then do the banks become active and the ready flag rise. An access that reaches a bank which is asleep or waking is refused through a per-bank stall output.

Top module: `flash_sleep_seq`

## Requirements
- R1: After reset every bank reads active, the pump is awake, `ready` is 1, `clk_off_ok` is 0 and no stall is raised.
- R2: A bank whose bit in `bank_fb_sleep` is 0 never leaves active. When `pump_fb_sleep` is 0 the pump never sleeps, and the clock permission is then never granted.
- R3: Bank i has a grace value G in `bank_grace[16i+15:16i]`. With its fall-back bit set, the bank enters sleep at the clock edge that ends its G+1-th consecutive idle cycle, so a G of 0 means sleep on the first idle edge. Any access restarts the idle run. Field i of `bank_state` (bits 2i+1:2i) reads 0 for active, 1 for asleep and 2 for waking.
- R4: With `pump_fb_sleep` set, `pump_sleep` rises at the first edge that finds every bank asleep and no wake in progress or requested. It is never 1 while any bank is not asleep.
- R5: `clk_off_ok` rises one edge after the pump has gone to sleep, and it is only ever 1 while the pump and all banks are asleep.
- R6: `clk_off_ok` is 0 after any edge that samples `wake_req` high.
- R7: The edge that samples `wake_req` while something is asleep and no wake is running wakes the pump and moves every sleeping bank to waking. Let N be `pump_ctrl[26:16]`. The banks return to active exactly 2N+1 edges later. The other bits of `pump_ctrl` have no effect.
- R8: `ready` is 1 only when the pump is awake, no wake is in progress, and every bank is active.
- R9: `bank_stall[i]` is 1 in the same cycle in which `bank_acc[i]` is high while bank i is not active.
- R10: While `wake_req` is high or a wake is in progress, no active bank counts towards sleep, so none enters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_acc | input | NB | Per-bank access strobe |
| bank_fb_sleep | input | NB | Per-bank fall-back mode, 1 means sleep when idle |
| pump_fb_sleep | input | 1 | Pump fall-back mode, 1 means sleep when allowed |
| bank_grace | input | NB*16 | Per-bank idle grace counts |
| pump_ctrl | input | 32 | Pump control word, wake count in bits 26:16 |
| wake_req | input | 1 | Request to bring the flash back to active |
| bank_state | output | NB*2 | Per-bank state code |
| pump_sleep | output | 1 | Pump is asleep |
| bank_stall | output | NB | Access refused, the bank is not active |
| ready | output | 1 | All banks and the pump are usable |
| clk_off_ok | output | 1 | Permission to stop the bus clock |

## Verification
The hazardous overlap is a wake request that arrives on the same edge at which a bank's grace run would end, or at which the pump would follow the last bank into sleep. The bench forces this with short grace values and frequent wake pulses in its random phase. It also runs a directed case in which the request is held high over many idle cycles. A cycle model in the bench predicts, for every edge, whether the bank was held active, whether the pump stayed awake, and whether the clock permission dropped. Each bank state, pump bit, ready flag and permission is compared with that prediction after every edge.

// File: rtl/flash_pm_pkg.sv
package flash_pm_pkg;

    localparam int BK_ST_W = 2;

    typedef enum logic [BK_ST_W-1:0] {
        BK_ACTIVE = 2'd0,
        BK_SLEEP  = 2'd1,
        BK_WAKING = 2'd2
    } bank_st_e;

endpackage

// File: rtl/flash_bank_ctl.sv
module flash_bank_ctl
    import flash_pm_pkg::*;
#(
    parameter int GRACE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_i,
    input  logic               fb_sleep_i,
    input  logic [GRACE_W-1:0] grace_i,
    input  logic               hold_i,
    input  logic               wake_i,
    input  logic               release_i,
    output bank_st_e           state_o,
    output logic               stall_o
);

    typedef struct packed {
        bank_st_e           st;
        logic [GRACE_W-1:0] idle;
    } bank_reg_t;

    bank_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            BK_ACTIVE: begin
                if (acc_i || hold_i || !fb_sleep_i) begin
                    r_d.idle = '0;
                end else if (r_q.idle == grace_i) begin
                    r_d.st   = BK_SLEEP;
                    r_d.idle = '0;
                end else begin
                    r_d.idle = r_q.idle + 1'b1;
                end
            end
            BK_SLEEP: begin
                if (wake_i) r_d.st = BK_WAKING;
            end
            BK_WAKING: begin
                if (release_i) begin
                    r_d.st   = BK_ACTIVE;
                    r_d.idle = '0;
                end
            end
            default: r_d.st = BK_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: BK_ACTIVE, idle: '0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;
    assign stall_o = acc_i && (r_q.st != BK_ACTIVE);

endmodule

// File: rtl/flash_pump_ctl.sv
module flash_pump_ctl #(
    parameter int WAKE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_sleep_i,
    input  logic              all_bank_sleep_i,
    input  logic              any_bank_sleep_i,
    input  logic              wake_req_i,
    input  logic [WAKE_W-1:0] wake_cnt_i,
    output logic              asleep_o,
    output logic              waking_o,
    output logic              wake_start_o,
    output logic              release_o,
    output logic              hold_o
);

    typedef struct packed {
        logic              asleep;
        logic              waking;
        logic              half;
        logic [WAKE_W-1:0] cnt;
    } pump_reg_t;

    pump_reg_t r_d, r_q;

    assign wake_start_o = wake_req_i && !r_q.waking && (r_q.asleep || any_bank_sleep_i);
    assign release_o    = r_q.waking && (r_q.cnt == '0);
    assign hold_o       = r_q.waking || wake_req_i;

    always_comb begin
        r_d = r_q;
        if (wake_start_o) begin
            r_d.asleep = 1'b0;
            r_d.waking = 1'b1;
            r_d.half   = 1'b0;
            r_d.cnt    = wake_cnt_i;
        end else if (release_o) begin
            r_d.waking = 1'b0;
            r_d.half   = 1'b0;
        end else if (r_q.waking) begin
            r_d.half = ~r_q.half;
            if (r_q.half) r_d.cnt = r_q.cnt - 1'b1;
        end else if (!r_q.asleep && !wake_req_i && fb_sleep_i && all_bank_sleep_i) begin
            r_d.asleep = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign asleep_o = r_q.asleep;
    assign waking_o = r_q.waking;

endmodule

// File: rtl/flash_sleep_seq.sv
module flash_sleep_seq
    import flash_pm_pkg::*;
#(
    parameter int NB      = 4,
    parameter int GRACE_W = 16,
    parameter int WAKE_W  = 11,
    parameter int WAKE_LSB = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NB-1:0]         bank_acc,
    input  logic [NB-1:0]         bank_fb_sleep,
    input  logic                  pump_fb_sleep,
    input  logic [NB*GRACE_W-1:0] bank_grace,
    input  logic [31:0]           pump_ctrl,
    input  logic                  wake_req,
    output logic [NB*BK_ST_W-1:0] bank_state,
    output logic                  pump_sleep,
    output logic [NB-1:0]         bank_stall,
    output logic                  ready,
    output logic                  clk_off_ok
);

    localparam int WAKE_MSB = WAKE_LSB + WAKE_W - 1;

    logic [NB-1:0] sleep_v, active_v;
    logic          all_sleep, any_sleep, all_active;
    logic          waking, wake_start, release_w, hold;
    logic [WAKE_W-1:0] wake_cnt;
    logic          unused_ctrl;

    assign wake_cnt    = pump_ctrl[WAKE_MSB:WAKE_LSB];
    assign unused_ctrl = ^{pump_ctrl[31:WAKE_MSB+1], pump_ctrl[WAKE_LSB-1:0]};

    for (genvar i = 0; i < NB; i++) begin : g_bank
        bank_st_e st;
        flash_bank_ctl #(.GRACE_W(GRACE_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_i     (bank_acc[i]),
            .fb_sleep_i(bank_fb_sleep[i]),
            .grace_i   (bank_grace[i*GRACE_W +: GRACE_W]),
            .hold_i    (hold),
            .wake_i    (wake_start),
            .release_i (release_w),
            .state_o   (st),
            .stall_o   (bank_stall[i])
        );
        assign bank_state[i*BK_ST_W +: BK_ST_W] = st;
        assign sleep_v[i]  = (st == BK_SLEEP);
        assign active_v[i] = (st == BK_ACTIVE);
    end

    assign all_sleep  = &sleep_v;
    assign any_sleep  = |sleep_v;
    assign all_active = &active_v;

    flash_pump_ctl #(.WAKE_W(WAKE_W)) pump_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .fb_sleep_i      (pump_fb_sleep),
        .all_bank_sleep_i(all_sleep),
        .any_bank_sleep_i(any_sleep),
        .wake_req_i      (wake_req),
        .wake_cnt_i      (wake_cnt),
        .asleep_o        (pump_sleep),
        .waking_o        (waking),
        .wake_start_o    (wake_start),
        .release_o       (release_w),
        .hold_o          (hold)
    );

    typedef struct packed {
        logic clk_off;
    } top_reg_t;

    top_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.clk_off = pump_sleep && all_sleep && !wake_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clk_off_ok = r_q.clk_off;
    assign ready      = !pump_sleep && !waking && all_active;

endmodule

// File: rtl/flash_sleep_seq_chk.sv
module flash_sleep_seq_chk #(
    parameter int NB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_req,
    input logic [NB-1:0]    bank_acc,
    input logic [NB-1:0]    bank_fb_sleep,
    input logic [NB*2-1:0]  bank_state,
    input logic             pump_sleep,
    input logic [NB-1:0]    bank_stall,
    input logic             ready,
    input logic             clk_off_ok
);

    logic [NB-1:0] sl_v, wk_v;
    for (genvar i = 0; i < NB; i++) begin : g_v
        assign sl_v[i] = (bank_state[2*i +: 2] == 2'd1);
        assign wk_v[i] = (bank_state[2*i +: 2] == 2'd2);

        assert_fb_off_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!bank_fb_sleep[i] && bank_state[2*i +: 2] == 2'd0) |=> (bank_state[2*i +: 2] == 2'd0));
        assert_access_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_acc[i] && bank_state[2*i +: 2] == 2'd0) |=> (bank_state[2*i +: 2] == 2'd0));
        assert_hold_no_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_req && bank_state[2*i +: 2] == 2'd0) |=> (bank_state[2*i +: 2] == 2'd0));
    end

    assert_pump_after_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pump_sleep |-> (&sl_v));
    assert_clk_off_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off_ok |-> (pump_sleep && (&sl_v)));
    assert_clk_off_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !clk_off_ok);
    assert_waking_pump_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wk_v) |-> !pump_sleep);
    assert_ready_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (bank_stall == '0));

endmodule

bind flash_sleep_seq flash_sleep_seq_chk #(.NB(NB)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_req     (wake_req),
    .bank_acc     (bank_acc),
    .bank_fb_sleep(bank_fb_sleep),
    .bank_state   (bank_state),
    .pump_sleep   (pump_sleep),
    .bank_stall   (bank_stall),
    .ready        (ready),
    .clk_off_ok   (clk_off_ok)
);

// File: tb/flash_sleep_seq_tb_top.sv
module flash_sleep_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int NB    = 4;
    localparam int GW    = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NB-1:0]     bank_acc;
    logic [NB-1:0]     bank_fb_sleep;
    logic              pump_fb_sleep;
    logic [NB*GW-1:0]  bank_grace;
    logic [31:0]       pump_ctrl;
    logic              wake_req;
    logic [NB*2-1:0]   bank_state;
    logic              pump_sleep;
    logic [NB-1:0]     bank_stall;
    logic              ready;
    logic              clk_off_ok;

    always #(CLK_P/2) clk = ~clk;

    flash_sleep_seq #(.NB(NB), .GRACE_W(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_acc(bank_acc), .bank_fb_sleep(bank_fb_sleep),
        .pump_fb_sleep(pump_fb_sleep), .bank_grace(bank_grace), .pump_ctrl(pump_ctrl),
        .wake_req(wake_req), .bank_state(bank_state), .pump_sleep(pump_sleep),
        .bank_stall(bank_stall), .ready(ready), .clk_off_ok(clk_off_ok)
    );

    int n_chk = 0;
    int n_err = 0;

    // cycle model state: bank code 0 active, 1 asleep, 2 waking
    int m_st[NB];
    int m_idle[NB];
    int m_pump, m_wk, m_dl, m_clk, cyc;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_states();
        int v = 0;
        for (int i = 0; i < NB; i++) v |= (m_st[i] << (2*i));
        return v;
    endfunction

    function automatic int model_ready();
        int ok = (m_pump == 0 && m_wk == 0) ? 1 : 0;
        for (int i = 0; i < NB; i++) if (m_st[i] != 0) ok = 0;
        return ok;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_idle[i] = 0; end
        m_pump = 0; m_wk = 0; m_dl = 0; m_clk = 0; cyc = 0;
    endtask

    task automatic tick();
        int n_st[NB];
        int n_idle[NB];
        int n_pump, n_wk, n_dl, n_clk, all_sl, any_sl, ws, rel, hold, g;
        #1;
        for (int i = 0; i < NB; i++)
            check("R9 stall", bank_stall[i], (bank_acc[i] && m_st[i] != 0) ? 1 : 0);
        all_sl = 1; any_sl = 0;
        for (int i = 0; i < NB; i++) begin
            if (m_st[i] != 1) all_sl = 0;
            if (m_st[i] == 1) any_sl = 1;
        end
        ws   = (wake_req && !m_wk && (m_pump || any_sl)) ? 1 : 0;
        rel  = (m_wk && cyc == m_dl) ? 1 : 0;
        hold = (wake_req || m_wk) ? 1 : 0;
        n_clk = (m_pump && all_sl && !wake_req) ? 1 : 0;
        n_pump = m_pump; n_wk = m_wk; n_dl = m_dl;
        if (ws) begin
            n_pump = 0; n_wk = 1; n_dl = cyc + 2*int'(pump_ctrl[26:16]) + 1;
        end else if (rel) begin
            n_wk = 0;
        end else if (!m_wk && !m_pump && !wake_req && pump_fb_sleep && all_sl) begin
            n_pump = 1;
        end
        for (int i = 0; i < NB; i++) begin
            n_st[i] = m_st[i]; n_idle[i] = m_idle[i];
            g = int'(bank_grace[i*GW +: GW]);
            if (m_st[i] == 0) begin
                if (bank_acc[i] || hold || !bank_fb_sleep[i]) n_idle[i] = 0;
                else begin
                    n_idle[i] = m_idle[i] + 1;
                    if (n_idle[i] == g + 1) begin n_st[i] = 1; n_idle[i] = 0; end
                end
            end else if (m_st[i] == 1) begin
                if (ws) n_st[i] = 2;
            end else if (rel) begin
                n_st[i] = 0; n_idle[i] = 0;
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NB; i++) begin m_st[i] = n_st[i]; m_idle[i] = n_idle[i]; end
        m_pump = n_pump; m_wk = n_wk; m_dl = n_dl; m_clk = n_clk; cyc++;
        check("R3 bank_state", int'(bank_state), model_states());
        check("R4 pump_sleep", int'(pump_sleep), m_pump);
        check("R5 clk_off_ok", int'(clk_off_ok), m_clk);
        check("R8 ready", int'(ready), model_ready());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bank_acc = '0; wake_req = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        model_reset();
        check("R1 bank_state", int'(bank_state), 0);
        check("R1 pump_sleep", int'(pump_sleep), 0);
        check("R1 ready", int'(ready), 1);
        check("R1 clk_off_ok", int'(clk_off_ok), 0);
        check("R1 bank_stall", int'(bank_stall), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        bank_fb_sleep = '1; pump_fb_sleep = 1'b1;
        bank_grace = {NB{16'd2}};
        pump_ctrl = 32'h8002_FFFF;   // wake count 2, junk elsewhere (R7)
        do_reset();

        // R3 R4 R5: grace 2 -> sleep after 3 idle edges, pump next, clock permission next
        tick(); tick();
        check("R3 still active", int'(bank_state), 8'h00);
        tick();
        check("R3 asleep", int'(bank_state), 8'h55);
        tick();
        check("R4 pump asleep", int'(pump_sleep), 1);
        check("R5 not yet", int'(clk_off_ok), 0);
        tick();
        check("R5 granted", int'(clk_off_ok), 1);

        // R6 R7: wake with count 2 -> banks active 5 edges after request edge
        wake_req = 1'b1;
        tick();
        check("R6 clk_off drop", int'(clk_off_ok), 0);
        check("R7 pump awake", int'(pump_sleep), 0);
        check("R7 banks waking", int'(bank_state), 8'hAA);
        wake_req = 1'b0;
        bank_acc = 4'b0010;
        #1;
        check("R9 stall waking", int'(bank_stall), 2);
        tick();
        bank_acc = '0;
        tick(); tick(); tick();
        check("R7 still waking", int'(bank_state), 8'hAA);
        check("R8 not ready", int'(ready), 0);
        tick();
        check("R7 active again", int'(bank_state), 8'h00);
        check("R8 ready", int'(ready), 1);

        // R2: bank 2 fall-back off
        bank_fb_sleep = 4'b1011; bank_grace = '0;
        do_reset();
        for (int k = 0; k < 8; k++) tick();
        check("R2 bank2 active", int'(bank_state), 8'h45);
        check("R2 pump awake", int'(pump_sleep), 0);
        check("R2 no clk_off", int'(clk_off_ok), 0);

        // R2: pump fall-back off
        bank_fb_sleep = '1; pump_fb_sleep = 1'b0;
        do_reset();
        for (int k = 0; k < 4; k++) tick();
        check("R2 banks asleep", int'(bank_state), 8'h55);
        check("R2 pump stays", int'(pump_sleep), 0);
        check("R2 no clk_off pump", int'(clk_off_ok), 0);

        // R10: wake request held over idle cycles keeps banks active
        pump_fb_sleep = 1'b1;
        do_reset();
        wake_req = 1'b1;
        for (int k = 0; k < 4; k++) tick();
        check("R10 held active", int'(bank_state), 8'h00);
        wake_req = 1'b0;
        tick();
        check("R3 grace zero", int'(bank_state), 8'h55);

        // random phase
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            if (k % 150 == 0) begin
                for (int i = 0; i < NB; i++) begin
                    bank_fb_sleep[i] = ($urandom % 8) != 0;
                    bank_grace[i*GW +: GW] = 16'($urandom % 6);
                end
                pump_fb_sleep = ($urandom % 6) != 0;
                pump_ctrl = $urandom;
                pump_ctrl[26:16] = 11'($urandom % 5);
            end
            for (int i = 0; i < NB; i++) bank_acc[i] = ($urandom % 9) == 0;
            wake_req = ($urandom % 25) == 0;
            tick();
        end
        bank_acc = '0; wake_req = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule